// File: doc/BRIEF.md
# Common-Strobe Multiplexed Bus Master

This block lets on-chip logic read and write byte registers in an external peripheral over an 8-bit bus that carries both the address and the data. There is one data strobe, and its meaning comes from a separate direction line: high for a read, low for a write. An access begins with an address phase. The address goes out on the bus and the address-latch line pulses high. After that the direction line settles, the chip select drops, and the data strobe is driven low for a fixed window. During that window the master either drives write data or samples read data.

The host side uses a request/acknowledge pair. A request is accepted in the cycle it meets `reqReady`. When the access finishes, a one-cycle `doneValid` pulse is raised, carrying read data when the access was a read. Every bus interval is a parameter in nanoseconds. It is rounded up to whole clock cycles with the clock period parameter. When an access ends, the direction line is held for a short time, then the block waits out a recovery interval before it accepts the next request. After a read it also waits a bus turnaround time. The bus is split into an output, an output enable and an input, so a pad ring can build the tristate.

Top module: `cs_bus_master`

## Requirements
- R1: While `rstN` is low, and from the moment it falls, `busAle`=0, `busCsN`=1, `busDsN`=1, `busRnw`=1, `busDoe`=0, `doneValid`=0 and `reqReady`=1.
- R2: `busAle` stays high for exactly ceil(max(ALE high, address setup)/clock) cycles (1 at the defaults). The request address is driven on `busDout`, with `busDoe`=1, while ALE is high and for the hold cycle after it falls.
- R3: `busRnw` takes its access value (0 = write, 1 = read) before `busDsN` falls, and it already has that value in the sample just before the fall.
- R4: `busDsN` is low for exactly ceil(strobe time/clock) consecutive cycles (4 at the defaults). `busCsN` is low in every cycle where `busDsN` is low.
- R5: `busDsN` falls exactly address-hold plus setup cycles after `busAle` falls (2 at the defaults). This meets both the ALE-to-strobe time and the direction setup time.
- R6: On a write, `busDout` carries the write data with `busDoe`=1 during the whole strobe. Data and `busRnw`=0 are held for the cycle after `busDsN` rises.
- R7: On a read, `busDoe` is 0 during the strobe. `busDin` is sampled in the last strobe cycle. `doneValid` pulses for one cycle, exactly in the cycle `busDsN` rises, and on a read `doneData` holds the sampled byte.
- R8: Counting from the cycle in which `busDsN` rises, the next `busAle` rise comes no sooner than hold + recovery cycles after a write. After a read the turnaround cycles are added as well. For back-to-back requests the gap is exactly hold + recovery (+ turnaround) + 1 idle cycle: 10 after a write and 11 after a read at the defaults.
- R9: When no access is in progress (`reqReady`=1), `busRnw`=1, `busDoe`=0, `busAle`=0 and both `busCsN` and `busDsN` are high.
- R10: `reqReady` is low from acceptance until the access and its recovery are complete. Each accepted request produces exactly one ALE pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host requests an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | DW | Register address sent in the address phase |
| reqWdata | input | DW | Write data |
| reqReady | output | 1 | Block idle; a request is accepted this cycle |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | DW | Read data, valid with doneValid on reads |
| busAle | output | 1 | Address latch enable, active high |
| busCsN | output | 1 | Chip select, active low |
| busDsN | output | 1 | Data strobe, active low |
| busRnw | output | 1 | Direction: 1 = read, 0 = write |
| busDout | output | DW | Multiplexed address/data output |
| busDoe | output | 1 | Output enable for busDout |
| busDin | input | DW | Multiplexed bus input from the pads |

## Verification
A wrong phase count or a skipped state in the sequencer shows up at the pins within the same access. ALE width, the ALE-to-strobe distance, strobe width and recovery gap are measured cycle by cycle, so an off-by-one is reported at the very edge where it occurs. A direction or enable decode error appears as a wrong `busRnw` at the strobe's falling edge, or as a contended bus during a read strobe. A capture taken in the wrong cycle returns a background byte that never matches the expected read data. A recovery counter loaded with the wrong length for the access type shows up as an exact gap mismatch at the next ALE rise.

// File: rtl/cs_bus_pkg.sv
package cs_bus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_AHOLD,
    PH_SETUP,
    PH_STROBE,
    PH_POST,
    PH_RECOVER
  } phaseT;

  // strobes from control to datapath, describing the next bus cycle
  typedef struct packed {
    logic ale;
    logic csN;
    logic dsN;
    logic rnw;
    logic driveAddr;
    logic driveData;
    logic load;
    logic capture;
  } busCtrlT;

  function automatic int nsToCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/cs_bus_ctrl.sv
module cs_bus_ctrl
  import cs_bus_pkg::*;
#(
  parameter int ALE_CYC    = 1,
  parameter int HOLD_CYC   = 1,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 4,
  parameter int POST_CYC   = 1,
  parameter int TURN_CYC   = 1,
  parameter int REC_CYC    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output busCtrlT ctrlNext
);

  localparam int REC_W_LEN = REC_CYC;
  localparam int REC_R_LEN = REC_CYC + TURN_CYC;
  localparam int MAX_LEN = maxOf(maxOf(maxOf(ALE_CYC, HOLD_CYC), maxOf(SETUP_CYC, STROBE_CYC)),
                                 maxOf(POST_CYC, REC_R_LEN));
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  phaseT phaseQ, phaseN;
  logic [CNT_W-1:0] cntQ, cntN;
  logic writeQ, writeN;
  logic accept;
  logic lastCyc;

  assign accept   = reqValid && (phaseQ == PH_IDLE);
  assign reqReady = (phaseQ == PH_IDLE);
  assign lastCyc  = (cntQ == '0);
  assign writeN   = accept ? reqWrite : writeQ;

  // phase sequencing with a per-phase down counter
  always_comb begin
    phaseN = phaseQ;
    cntN   = cntQ;
    if (phaseQ != PH_IDLE && !lastCyc) begin
      cntN = cntQ - 1'b1;
    end else begin
      unique case (phaseQ)
        PH_IDLE: if (reqValid) begin
          phaseN = PH_ALE;
          cntN   = CNT_W'(ALE_CYC - 1);
        end
        PH_ALE: begin
          phaseN = PH_AHOLD;
          cntN   = CNT_W'(HOLD_CYC - 1);
        end
        PH_AHOLD: begin
          phaseN = PH_SETUP;
          cntN   = CNT_W'(SETUP_CYC - 1);
        end
        PH_SETUP: begin
          phaseN = PH_STROBE;
          cntN   = CNT_W'(STROBE_CYC - 1);
        end
        PH_STROBE: begin
          phaseN = PH_POST;
          cntN   = CNT_W'(POST_CYC - 1);
        end
        PH_POST: begin
          phaseN = PH_RECOVER;
          cntN   = writeQ ? CNT_W'(REC_W_LEN - 1) : CNT_W'(REC_R_LEN - 1);
        end
        PH_RECOVER: begin
          phaseN = PH_IDLE;
          cntN   = '0;
        end
        default: begin
          phaseN = PH_IDLE;
          cntN   = '0;
        end
      endcase
    end
  end

  // pin decode for the phase about to be entered
  always_comb begin
    ctrlNext.ale       = 1'b0;
    ctrlNext.csN       = 1'b1;
    ctrlNext.dsN       = 1'b1;
    ctrlNext.rnw       = 1'b1;
    ctrlNext.driveAddr = 1'b0;
    ctrlNext.driveData = 1'b0;
    ctrlNext.load      = accept;
    ctrlNext.capture   = (phaseQ == PH_STROBE) && lastCyc;
    unique case (phaseN)
      PH_ALE: begin
        ctrlNext.ale       = 1'b1;
        ctrlNext.driveAddr = 1'b1;
      end
      PH_AHOLD: begin
        ctrlNext.driveAddr = 1'b1;
        ctrlNext.rnw       = !writeN;
      end
      PH_SETUP: begin
        ctrlNext.csN       = 1'b0;
        ctrlNext.rnw       = !writeN;
        ctrlNext.driveData = writeN;
      end
      PH_STROBE: begin
        ctrlNext.csN       = 1'b0;
        ctrlNext.dsN       = 1'b0;
        ctrlNext.rnw       = !writeN;
        ctrlNext.driveData = writeN;
      end
      PH_POST: begin
        ctrlNext.rnw       = !writeN;
        ctrlNext.driveData = writeN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      writeQ <= 1'b0;
    end else begin
      phaseQ <= phaseN;
      cntQ   <= cntN;
      writeQ <= writeN;
    end
  end

  // R10
  // no new acceptance may occur while an access runs
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_STROBE) |=> (phaseQ != PH_ALE));

endmodule

// File: rtl/cs_bus_dpath.sv
module cs_bus_dpath
  import cs_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  busCtrlT       ctrlNext,
  input  logic [DW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] busDin,
  output logic          doneValid,
  output logic [DW-1:0] doneData,
  output logic          busAle,
  output logic          busCsN,
  output logic          busDsN,
  output logic          busRnw,
  output logic [DW-1:0] busDout,
  output logic          busDoe
);

  logic [DW-1:0] addrQ;
  logic [DW-1:0] dataQ;
  logic [DW-1:0] doutNext;

  always_comb begin
    if (ctrlNext.driveAddr)      doutNext = ctrlNext.load ? reqAddr : addrQ;
    else if (ctrlNext.driveData) doutNext = dataQ;
    else                         doutNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAle    <= 1'b0;
      busCsN    <= 1'b1;
      busDsN    <= 1'b1;
      busRnw    <= 1'b1;
      busDoe    <= 1'b0;
      busDout   <= '0;
      addrQ     <= '0;
      dataQ     <= '0;
      doneValid <= 1'b0;
      doneData  <= '0;
    end else begin
      busAle    <= ctrlNext.ale;
      busCsN    <= ctrlNext.csN;
      busDsN    <= ctrlNext.dsN;
      busRnw    <= ctrlNext.rnw;
      busDoe    <= ctrlNext.driveAddr | ctrlNext.driveData;
      busDout   <= doutNext;
      doneValid <= ctrlNext.capture;
      if (ctrlNext.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
      end
      if (ctrlNext.capture && busRnw) doneData <= busDin;
    end
  end

  // R2
  ale_drives_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> busDoe);

  // R3
  rnw_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busDsN) |-> $stable(busRnw));

  // R4
  cs_encloses_ds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busDsN |-> !busCsN);

  // R6
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busDsN) && !busRnw) |-> busDoe);

  // R7
  done_at_ds_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $rose(busDsN));

  // R7
  no_read_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busDsN && busRnw) |-> !busDoe);

endmodule

// File: rtl/cs_bus_master.sv
module cs_bus_master
  import cs_bus_pkg::*;
#(
  parameter int DW            = 8,
  parameter int CLK_NS        = 20,
  parameter int ALE_HIGH_NS   = 20,
  parameter int ADDR_SETUP_NS = 15,
  parameter int ADDR_HOLD_NS  = 8,
  parameter int ALE_TO_DS_NS  = 15,
  parameter int RNW_SETUP_NS  = 8,
  parameter int RNW_HOLD_NS   = 8,
  parameter int STROBE_NS     = 65,
  parameter int DATA_HOLD_NS  = 8,
  parameter int TURN_NS       = 20,
  parameter int RECOVER_NS    = 150
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [DW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          reqReady,
  output logic          doneValid,
  output logic [DW-1:0] doneData,
  output logic          busAle,
  output logic          busCsN,
  output logic          busDsN,
  output logic          busRnw,
  output logic [DW-1:0] busDout,
  output logic          busDoe,
  input  logic [DW-1:0] busDin
);

  localparam int ALE_CYC    = atLeastOne(nsToCyc(maxOf(ALE_HIGH_NS, ADDR_SETUP_NS), CLK_NS));
  localparam int HOLD_CYC   = atLeastOne(nsToCyc(ADDR_HOLD_NS, CLK_NS));
  localparam int SETUP_CYC  = atLeastOne(maxOf(nsToCyc(ALE_TO_DS_NS, CLK_NS) - HOLD_CYC,
                                               nsToCyc(RNW_SETUP_NS, CLK_NS) - HOLD_CYC));
  localparam int STROBE_CYC = atLeastOne(nsToCyc(STROBE_NS, CLK_NS));
  localparam int POST_CYC   = atLeastOne(nsToCyc(maxOf(RNW_HOLD_NS, DATA_HOLD_NS), CLK_NS));
  localparam int TURN_CYC   = nsToCyc(TURN_NS, CLK_NS);
  localparam int REC_CYC    = atLeastOne(nsToCyc(RECOVER_NS, CLK_NS));

  busCtrlT ctrlNext;

  cs_bus_ctrl #(
    .ALE_CYC   (ALE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .POST_CYC  (POST_CYC),
    .TURN_CYC  (TURN_CYC),
    .REC_CYC   (REC_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .ctrlNext(ctrlNext)
  );

  cs_bus_dpath #(
    .DW(DW)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlNext (ctrlNext),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busDin   (busDin),
    .doneValid(doneValid),
    .doneData (doneData),
    .busAle   (busAle),
    .busCsN   (busCsN),
    .busDsN   (busDsN),
    .busRnw   (busRnw),
    .busDout  (busDout),
    .busDoe   (busDoe)
  );

endmodule

// File: tb/sim_cs_bus_master.sv
module sim_cs_bus_master;

  // expected cycle counts at 20 ns clock and default timings
  localparam int ALE_EXP    = 1;   // ceil(20/20)
  localparam int A2D_EXP    = 2;   // hold 1 + setup 1
  localparam int STROBE_EXP = 4;   // ceil(65/20)
  localparam int GAP_W_EXP  = 10;  // hold 1 + recovery 8 + idle 1
  localparam int GAP_R_EXP  = 11;  // plus turnaround 1
  localparam int NVEC = 9;
  // {write, addr, wdata, expected read data}
  localparam logic [24:0] VECS [NVEC] = '{
    {1'b1, 8'h12, 8'hA5, 8'h00},
    {1'b1, 8'h34, 8'h3C, 8'h00},
    {1'b0, 8'h12, 8'h00, 8'hA5},
    {1'b0, 8'h34, 8'h00, 8'h3C},
    {1'b1, 8'hFF, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'h5A},
    {1'b1, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqAddr = '0, reqWdata = '0, reqExp = '0;
  logic reqReady, doneValid, busAle, busCsN, busDsN, busRnw, busDoe;
  logic [7:0] doneData, busDout, busDin;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] mem [256];
  logic [7:0] perAddr = '0;

  always #10 clk = ~clk;

  cs_bus_master u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .doneValid(doneValid), .doneData(doneData), .busAle(busAle),
    .busCsN(busCsN), .busDsN(busDsN), .busRnw(busRnw), .busDout(busDout),
    .busDoe(busDoe), .busDin(busDin)
  );

  // peripheral model: drives data only during a read strobe
  assign busDin = (!busDsN && busRnw) ? mem[perAddr] : 8'hEE;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [7:0] a, input logic [7:0] d, input logic [7:0] e);
    reqWrite = w; reqAddr = a; reqWdata = d; reqExp = e; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // record accepted request
  logic accWrite = 1'b0;
  logic [7:0] accAddr = '0, accData = '0, accExp = '0;
  int acceptCnt = 0;
  always @(posedge clk) begin
    if (rstN && reqValid && reqReady) begin
      accWrite  <= reqWrite;
      accAddr   <= reqAddr;
      accData   <= reqWdata;
      accExp    <= reqExp;
      acceptCnt <= acceptCnt + 1;
    end
  end

  // bus monitor
  logic pAle = 1'b0, pDsN = 1'b1, pRnw = 1'b1;
  int aleCnt = 0, a2dCnt = 0, dsCnt = 0, gapCnt = 0, aleRises = 0;
  bit counting = 0, haveGap = 0, gapExact = 0, lastWasWrite = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      pAle = 1'b0; pDsN = 1'b1; pRnw = 1'b1;
      counting = 0; haveGap = 0; aleCnt = 0; dsCnt = 0;
    end else begin
      if (reqReady)
        chk(busRnw && !busDoe && !busAle && busCsN && busDsN, "R9 idle pins",
            {busRnw, busDoe, busAle, busCsN, busDsN}, 5'b10011);
      if (busAle || !busCsN || !busDsN)
        chk(!reqReady, "R10 ready during access", reqReady, 0);
      if (busAle) begin
        chk(busDoe && busDout == accAddr, "R2 address during ALE", busDout, accAddr);
        if (!pAle) begin
          aleRises++;
          aleCnt = 0;
          if (haveGap) begin
            int expGap;
            expGap = lastWasWrite ? GAP_W_EXP : GAP_R_EXP;
            if (gapExact) chk(gapCnt == expGap, "R8 recovery gap", gapCnt, expGap);
            else chk(gapCnt >= expGap, "R8 minimum recovery gap", gapCnt, expGap);
          end
          haveGap = 0;
        end
        aleCnt++;
      end
      if (pAle && !busAle) begin
        chk(aleCnt == ALE_EXP, "R2 ALE width", aleCnt, ALE_EXP);
        chk(busDoe && busDout == accAddr, "R2 address hold", busDout, accAddr);
        perAddr = busDout;
        a2dCnt = 0;
        counting = 1;
      end
      if (counting && busDsN) a2dCnt++;
      if (!busDsN) begin
        chk(!busCsN, "R4 select encloses strobe", busCsN, 0);
        if (pDsN) begin
          chk(a2dCnt == A2D_EXP, "R5 ALE fall to strobe", a2dCnt, A2D_EXP);
          chk(busRnw == !accWrite && pRnw == busRnw, "R3 direction setup",
              {pRnw, busRnw}, {!accWrite, !accWrite});
          counting = 0;
          dsCnt = 0;
        end
        dsCnt++;
        if (accWrite) chk(busDoe && busDout == accData, "R6 write data in strobe", busDout, accData);
        else chk(!busDoe, "R7 bus released in read strobe", busDoe, 0);
      end
      chk(doneValid == (!pDsN && busDsN), "R7 done pulse timing", doneValid, !pDsN && busDsN);
      if (!pDsN && busDsN) begin
        chk(dsCnt == STROBE_EXP, "R4 strobe width", dsCnt, STROBE_EXP);
        if (accWrite) begin
          chk(busDoe && busDout == accData && !busRnw, "R6 write hold",
              {busDoe, busRnw, busDout}, {1'b1, 1'b0, accData});
          mem[perAddr] = busDout;
        end else begin
          chk(doneData == accExp, "R7 read data", doneData, accExp);
        end
        gapCnt = 0;
        haveGap = 1;
        lastWasWrite = accWrite;
      end
      if (haveGap && busDsN && !busAle) gapCnt++;
      pAle = busAle; pDsN = busDsN; pRnw = busRnw;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      failures++;
      checks++;
      $display("FAIL R10 watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    @(negedge clk);
    // R1 reset state
    chk(!busAle && busCsN && busDsN && busRnw && !busDoe && !doneValid && reqReady,
        "R1 reset state", {busAle, busCsN, busDsN, busRnw, busDoe, doneValid, reqReady}, 7'b0111001);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    gapExact = 1;
    for (int v = 0; v < NVEC; v++) begin
      issue(VECS[v][24], VECS[v][23:16], VECS[v][15:8], VECS[v][7:0]);
    end
    while (!reqReady) @(negedge clk);
    gapExact = 0;

    // R1 reset in the middle of a read strobe
    issue(1'b0, 8'h12, 8'h00, 8'hA5);
    while (busDsN) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(!busAle && busCsN && busDsN && busRnw && !busDoe && !doneValid && reqReady,
        "R1 abort by reset", {busAle, busCsN, busDsN, busRnw, busDoe, doneValid, reqReady}, 7'b0111001);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // fresh access after abort, then long idle
    issue(1'b0, 8'h34, 8'h00, 8'h3C);
    while (!reqReady) @(negedge clk);
    for (int k = 0; k < 20; k++) @(negedge clk);
    // R9 long idle
    chk(busRnw && !busDoe, "R9 long idle direction", {busRnw, busDoe}, 2'b10);
    // R8 minimum gap after idle
    issue(1'b1, 8'h55, 8'h99, 8'h00);
    while (!reqReady) @(negedge clk);
    issue(1'b0, 8'h55, 8'h00, 8'h99);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    // R10 one ALE per accepted request
    chk(aleRises == acceptCnt, "R10 one ALE per request", aleRises, acceptCnt);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule